// File: doc/BRIEF.md
# ADC Result Format Converter

This block sits on the read path of an analog-to-digital converter's result store. The store keeps each 10-bit conversion code in raw unsigned form. When a result is read, this stage turns the raw code into a 32-bit word in one of eight formats. A 3-bit select picks the format. The four number kinds are unsigned integer, signed integer, unsigned fraction and signed fraction, and each comes in a 16-bit and a 32-bit width.

The signed kinds treat the code as offset binary around mid-scale 512. They invert the top code bit and use it as the sign. The fractional kinds left-justify the 10 code bits into the top of the 16-bit or 32-bit field and zero-fill the bits below. In the 16-bit kinds, any sign extension stops at bit 15 and bits 31:16 read as zero. In the 32-bit kinds, sign extension fills the whole word.

The stage is a single register. The word shown in one cycle reflects the code and select that were present at the previous rising clock edge.

Top module: `adc_result_fmt`

## Requirements
- R1: While rst_ni is low, data_o is zero.
- R2: data_o is updated one cycle after its inputs. The word it shows reflects code_i and fmt_i as sampled at the preceding rising edge of clk_i. Select bits: fmt_i[2]=1 selects 32-bit width, fmt_i[1]=1 selects fractional, fmt_i[0]=1 selects signed.
- R3: Unsigned integer (fmt_i 000 or 100): data_o is code_i zero-extended to 32 bits.
- R4: 32-bit signed integer (fmt_i 101): data_o is code_i minus 512 in two's complement, with the sign extended over all 32 bits.
- R5: 16-bit signed integer (fmt_i 001): bits 15:0 hold code_i minus 512 in 16-bit two's complement, and bits 31:16 are zero.
- R6: 16-bit unsigned fraction (fmt_i 010): code_i sits in bits 15:6, and all other bits are zero.
- R7: 32-bit unsigned fraction (fmt_i 110): code_i sits in bits 31:22, and bits 21:0 are zero.
- R8: Signed fraction (fmt_i 011 or 111): the code with bit 9 inverted is placed at the same bit positions as the matching unsigned fraction. The result reads as the two's complement of code_i minus 512, scaled by 2^6 for 16-bit or 2^22 for 32-bit.
- R9: Every 16-bit format (fmt_i[2]=0) gives zero in bits 31:16.
- R10: The 16-bit and 32-bit variants of a kind carry the same value. For integers, the low 16 bits of the 32-bit word equal the 16-bit word. For fractions, the 32-bit word shifted right by 16 equals the 16-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 10 | Raw unsigned conversion code |
| fmt_i | input | 3 | Format select: [2] 32-bit, [1] fractional, [0] signed |
| data_o | output | 32 | Formatted read word |

## Verification
The assertions assume that code_i and fmt_i are settled at every rising edge, and that each check relates the output to the inputs captured one edge earlier. No check starts until a first edge has passed since reset, so no check relies on inputs that were sampled while reset was active. The bench changes the inputs only on falling edges and reads the output on the following falling edge. As a result, each input pair is captured by exactly one rising edge before it is checked.

// File: rtl/adc_result_fmt_pkg.sv
package adc_result_fmt_pkg;
  localparam int unsigned CODE_W   = 10;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned OUT_W    = 32;

  typedef struct packed {
    logic wide;  // 1: 32-bit field
    logic frac;  // 1: left-justified
    logic sgn;   // 1: offset binary -> two's complement
  } fmt_sel_t;
endpackage

// File: rtl/adc_result_fmt_recode.sv
module adc_result_fmt_recode #(
  parameter int unsigned CODE_W = 10
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              sgn_i,
  output logic [CODE_W-1:0] val_o
);
  // mid-scale offset removal: flip the top bit
  always_comb begin
    val_o = code_i;
    if (sgn_i) val_o[CODE_W-1] = ~code_i[CODE_W-1];
  end
endmodule

// File: rtl/adc_result_fmt_place.sv
module adc_result_fmt_place #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned OUT_W   = 32
) (
  input  logic [CODE_W-1:0] val_i,
  input  logic              sgn_i,
  input  logic              frac_i,
  output logic [OUT_W-1:0]  word_o
);
  localparam int unsigned PAD_W = FIELD_W - CODE_W;

  logic [FIELD_W-1:0] field;
  logic               ext_bit;

  assign ext_bit = sgn_i & val_i[CODE_W-1];

  always_comb begin
    if (frac_i) field = {val_i, {PAD_W{1'b0}}};
    else        field = {{PAD_W{ext_bit}}, val_i};
  end

  generate
    if (OUT_W > FIELD_W) begin : g_pad
      assign word_o = {{(OUT_W-FIELD_W){1'b0}}, field};
    end else begin : g_full
      assign word_o = field;
    end
  endgenerate
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_result_fmt_pkg::*;
#(
  parameter int unsigned CODE_W   = adc_result_fmt_pkg::CODE_W,
  parameter int unsigned NARROW_W = adc_result_fmt_pkg::NARROW_W,
  parameter int unsigned OUT_W    = adc_result_fmt_pkg::OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [2:0]        fmt_i,
  output logic [OUT_W-1:0]  data_o
);
  localparam int unsigned N_WIDTHS = 2;

  fmt_sel_t           sel;
  logic [CODE_W-1:0]  val;
  logic [OUT_W-1:0]   cand [N_WIDTHS];
  logic [OUT_W-1:0]   data_d;

  assign sel = fmt_sel_t'(fmt_i);

  adc_result_fmt_recode #(.CODE_W(CODE_W)) u_recode (
    .code_i (code_i),
    .sgn_i  (sel.sgn),
    .val_o  (val)
  );

  // index 0: narrow field, index 1: full-width field
  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int unsigned FW = (g == 0) ? NARROW_W : OUT_W;
    adc_result_fmt_place #(
      .CODE_W (CODE_W),
      .FIELD_W(FW),
      .OUT_W  (OUT_W)
    ) u_place (
      .val_i  (val),
      .sgn_i  (sel.sgn),
      .frac_i (sel.frac),
      .word_o (cand[g])
    );
  end

  assign data_d = sel.wide ? cand[1] : cand[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= data_d;
  end
endmodule

// File: rtl/adc_result_fmt_chk.sv
module adc_result_fmt_chk
  import adc_result_fmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic [2:0]        fmt_i,
  input logic [OUT_W-1:0]  data_o
);
  localparam int unsigned NPAD = NARROW_W - CODE_W;
  localparam int unsigned WPAD = OUT_W - CODE_W;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_uint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(fmt_i[1]) && !$past(fmt_i[0])
    |-> data_o == {{WPAD{1'b0}}, $past(code_i)});

  p_sint_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(fmt_i) == 3'b101)
    |-> (data_o[OUT_W-1:CODE_W-1] == {(WPAD+1){~$past(code_i[CODE_W-1])}})
        && (data_o[CODE_W-2:0] == $past(code_i[CODE_W-2:0])));

  p_frac_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(fmt_i[1]) && !$past(fmt_i[2])
    |-> (data_o[NPAD-1:0] == '0)
        && (data_o[NARROW_W-2:NPAD] == $past(code_i[CODE_W-2:0])));

  p_frac_wide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(fmt_i[1]) && $past(fmt_i[2])
    |-> (data_o[WPAD-1:0] == '0)
        && (data_o[OUT_W-2:WPAD] == $past(code_i[CODE_W-2:0])));

  p_sfrac_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(fmt_i[1]) && $past(fmt_i[0]) && $past(fmt_i[2])
    |-> data_o[OUT_W-1] != $past(code_i[CODE_W-1]));

  p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(fmt_i[2])
    |-> data_o[OUT_W-1:NARROW_W] == '0);
endmodule

bind adc_result_fmt adc_result_fmt_chk chk_i (.*);

// File: tb/adc_result_fmt_tb_top.sv
module adc_result_fmt_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  code_i = '0;
  logic [2:0]  fmt_i = '0;
  logic [31:0] data_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  adc_result_fmt dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(code_i),
    .fmt_i (fmt_i),
    .data_o(data_o)
  );

  function automatic logic [31:0] ref_word(input logic [9:0] c, input logic [2:0] f);
    int v;
    logic [15:0] n;
    v = f[0] ? (int'(c) - 512) : int'(c);
    if (f[1]) begin
      if (f[2]) return 32'(v * (1 << 22));
      n = 16'(v * 64);
      return {16'h0, n};
    end
    if (f[2]) return 32'(v);
    n = 16'(v);
    return {16'h0, n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [9:0] c, input logic [2:0] f);
    @(negedge clk_i);
    code_i = c;
    fmt_i  = f;
    @(negedge clk_i);
    check(req, data_o, ref_word(c, f));
  endtask

  task automatic t_reset;  // R1
    code_i = 10'h3FF;
    fmt_i  = 3'b111;
    repeat (3) @(negedge clk_i);
    check("R1", data_o, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_latency;  // R2
    @(negedge clk_i);
    code_i = 10'h155; fmt_i = 3'b000;
    @(negedge clk_i);
    code_i = 10'h2AA; fmt_i = 3'b100;
    #1 check("R2", data_o, 32'h0000_0155);
    @(negedge clk_i);
    check("R2", data_o, 32'h0000_02AA);
  endtask

  task automatic t_uint;  // R3
    apply("R3", 10'h000, 3'b000);
    apply("R3", 10'h3FF, 3'b000);
    apply("R3", 10'h3FF, 3'b100);
    check("R3", data_o, 32'h0000_03FF);
  endtask

  task automatic t_sint_wide;  // R4
    apply("R4", 10'h000, 3'b101);
    check("R4", data_o, 32'hFFFF_FE00);
    apply("R4", 10'h1FF, 3'b101);
    apply("R4", 10'h200, 3'b101);
    apply("R4", 10'h3FF, 3'b101);
    check("R4", data_o, 32'h0000_01FF);
  endtask

  task automatic t_sint_narrow;  // R5
    apply("R5", 10'h000, 3'b001);
    check("R5", data_o, 32'h0000_FE00);
    apply("R5", 10'h201, 3'b001);
    apply("R5", 10'h1FF, 3'b001);
  endtask

  task automatic t_frac;  // R6 R7
    apply("R6", 10'h3FF, 3'b010);
    check("R6", data_o, 32'h0000_FFC0);
    apply("R6", 10'h001, 3'b010);
    apply("R7", 10'h3FF, 3'b110);
    check("R7", data_o, 32'hFFC0_0000);
    apply("R7", 10'h001, 3'b110);
  endtask

  task automatic t_sfrac;  // R8
    apply("R8", 10'h000, 3'b011);
    check("R8", data_o, 32'h0000_8000);
    apply("R8", 10'h3FF, 3'b011);
    apply("R8", 10'h000, 3'b111);
    check("R8", data_o, 32'h8000_0000);
    apply("R8", 10'h200, 3'b111);
    apply("R8", 10'h155, 3'b111);
  endtask

  task automatic t_upper_zero;  // R9
    for (int f = 0; f < 4; f++) begin
      apply("R9", 10'h000, 3'(f));
      check("R9", {16'h0, data_o[31:16]}, 32'h0);
    end
  endtask

  task automatic t_width_match;  // R10
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      logic [9:0] c;
      c = 10'(k * 300 + 7);
      apply("R10", c, 3'b101); w = data_o;
      apply("R10", c, 3'b001);
      check("R10", {16'h0, w[15:0]}, data_o);
      apply("R10", c, 3'b111); w = data_o;
      apply("R10", c, 3'b011);
      check("R10", {16'h0, w[31:16]}, data_o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_uint();
    t_sint_wide();
    t_sint_narrow();
    t_frac();
    t_sfrac();
    t_upper_zero();
    t_width_match();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule